// File: doc/BRIEF.md
# Watchdog Countdown Timer with Bus Register Block

This block is a watchdog timer attached to a memory-mapped bus as an APB slave. Software writes a reload value and sets an enable bit. A 32-bit down-counter then runs. When the counter reaches zero, the block raises an interrupt and reloads the counter from the stored reload value. Software services the watchdog by writing the clear register. That write drops the interrupt and starts the countdown again from the reload value. If software fails to service it, and reset generation is enabled, the next expiry raises a reset request. This request stays high until the block itself is reset.

The bus side and the counter share one clock. A single state machine tracks the interrupt and reset outputs. Its states are IRQ_IDLE (nothing pending), IRQ_PENDING (interrupt raised and not yet cleared) and IRQ_RESET (reset request issued, terminal). Its transitions are:
- IRQ_IDLE to IRQ_PENDING on expiry.
- IRQ_PENDING to IRQ_IDLE on a clear write.
- IRQ_PENDING to IRQ_RESET on expiry while reset generation is enabled.

Each clock, the counter takes exactly one action, chosen by a fixed priority: ACT_LOAD (a nonzero reload write), ACT_CLEAR (a clear write), ACT_EXPIRE (running at zero), ACT_DEC (running, nonzero) and ACT_HOLD (stopped).

Register offsets (byte addresses):

| Offset | Register | Access | Contents |
|---|---|---|---|
| 0x00 | reload | read/write | 32-bit reload value |
| 0x04 | count | read-only | current count |
| 0x08 | control | read/write | bit 0 = interrupt/run enable, bit 1 = reset enable |
| 0x0C | clear | write-only | a write with data bit 0 set services the watchdog |
| 0x10 | raw status | read-only | bit 0 = raw interrupt |
| 0x14 | masked status | read-only | bit 0 = raw interrupt AND enable |

Top module: `wdog_timer`

## Requirements
- R1: After reset, the reload register and count register read 0xFFFFFFFF, control reads 0, and both the interrupt and reset outputs are low.
- R2: Registers sit at the offsets above. Every other offset reads 0. pready is always 1, so every access completes with no wait states.
- R3: The count decreases by one on each clock while control bit 0 is set. It holds its value while that bit is clear. A control write takes effect from the clock after its write edge.
- R4: A nonzero write to the reload register sets the count to the written value at the write edge, whether or not the counter is running. A zero write is stored and read back, but leaves the count unchanged.
- R5: When the counter is running at count 0, the next clock sets the raw interrupt and reloads the count from the reload register. With enable set, a reload of N written at edge B raises the interrupt output at edge B+N+1.
- R6: Once set, the raw interrupt stays set through reload writes, control writes and clear writes whose data bit 0 is 0.
- R7: A write to the clear register with data bit 0 set drops the interrupt at its write edge and sets the count to the reload value.
- R8: The interrupt output equals the raw interrupt ANDed with control bit 0. Raw status returns the raw interrupt in bit 0. Masked status returns the output value in bit 0.
- R9: If the counter expires again while the interrupt is pending and control bit 1 is set, the reset output rises. It stays high, ignoring clear writes, until rst_n is asserted.
- R10: An expiry with no interrupt pending never raises the reset output, even when control bit 1 is set.
- R11: A reload write or clear write that lands on the same edge as an expiry wins. The count restarts from the written value, and that expiry raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the bus and the counter |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W (8) | APB byte address |
| pwdata | input | DATA_W (32) | APB write data |
| prdata | output | DATA_W (32) | APB read data |
| pready | output | 1 | APB ready, always high |
| wdog_irq | output | 1 | Masked watchdog interrupt |
| wdog_rst | output | 1 | Sticky reset request |

## Verification
The hardest situation to reach is a reload write whose write edge coincides exactly with an expiry. Reaching it needs the APB write phases to be placed to the very cycle at which the count hits zero. The stimulus loads a count of 3 and idles a computed number of cycles. It then issues a second reload so that its write edge falls on the expiry edge, and checks that no interrupt appears until the new count runs out. The reset path is reached the same way: the bench counts edges from a short reload through two unserviced expiries, and checks the reset pin on the exact edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int OFF_RELOAD = 'h00;
    localparam int OFF_COUNT  = 'h04;
    localparam int OFF_CTRL   = 'h08;
    localparam int OFF_CLEAR  = 'h0C;
    localparam int OFF_RAW    = 'h10;
    localparam int OFF_MASKED = 'h14;

    typedef enum logic [1:0] {
        IRQ_IDLE,
        IRQ_PENDING,
        IRQ_RESET
    } irq_state_t;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_DEC,
        ACT_EXPIRE,
        ACT_LOAD,
        ACT_CLEAR
    } cnt_act_t;

endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W-1:0] count,
    input  logic              raw_irq,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic [DATA_W-1:0] reload_val,
    output logic [DATA_W-1:0] reload_new,
    output logic              run_en,
    output logic              rst_en,
    output logic              reload_wr,
    output logic              clear_wr
);

    localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFF_RELOAD);
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFF_CLEAR);
    localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFF_RAW);
    localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFF_MASKED);

    logic wr_access;
    logic rd_access;
    logic ctrl_wr;

    assign wr_access  = psel && penable && pwrite;
    assign rd_access  = psel && !pwrite;
    assign ctrl_wr    = wr_access && (paddr == A_CTRL);
    assign reload_wr  = wr_access && (paddr == A_RELOAD) && (pwdata != '0);
    assign clear_wr   = wr_access && (paddr == A_CLEAR) && pwdata[0];
    assign reload_new = pwdata;
    assign pready     = 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_val <= '1;
        end else if (wr_access && (paddr == A_RELOAD)) begin
            reload_val <= pwdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_en <= 1'b0;
            rst_en <= 1'b0;
        end else if (ctrl_wr) begin
            run_en <= pwdata[0];
            rst_en <= pwdata[1];
        end
    end

    always_comb begin
        prdata = '0;
        if (rd_access) begin
            case (paddr)
                A_RELOAD: prdata = reload_val;
                A_COUNT:  prdata = count;
                A_CTRL:   prdata = {{(DATA_W-2){1'b0}}, rst_en, run_en};
                A_RAW:    prdata = {{(DATA_W-1){1'b0}}, raw_irq};
                A_MASKED: prdata = {{(DATA_W-1){1'b0}}, raw_irq & run_en};
                default:  prdata = '0;
            endcase
        end
    end

    // R4: a zero write lands in the reload register
    p_zero_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_access && (paddr == A_RELOAD) && (pwdata == '0)) |=> (reload_val == '0));

    // R3: control takes the written bits
    p_ctrl_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (run_en == $past(pwdata[0])) && (rst_en == $past(pwdata[1])));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              reload_wr,
    input  logic [DATA_W-1:0] reload_new,
    input  logic              clear_wr,
    input  logic [DATA_W-1:0] reload_val,
    output logic [DATA_W-1:0] count,
    output logic              expire
);

    cnt_act_t          act;
    logic [DATA_W-1:0] count_nxt;

    always_comb begin
        if (reload_wr) begin
            act = ACT_LOAD;
        end else if (clear_wr) begin
            act = ACT_CLEAR;
        end else if (run_en) begin
            act = (count == '0) ? ACT_EXPIRE : ACT_DEC;
        end else begin
            act = ACT_HOLD;
        end
    end

    always_comb begin
        unique case (act)
            ACT_LOAD:   count_nxt = reload_new;
            ACT_CLEAR:  count_nxt = reload_val;
            ACT_EXPIRE: count_nxt = reload_val;
            ACT_DEC:    count_nxt = count - 1'b1;
            ACT_HOLD:   count_nxt = count;
            default:    count_nxt = count;
        endcase
    end

    assign expire = (act == ACT_EXPIRE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '1;
        end else begin
            count <= count_nxt;
        end
    end

    p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !reload_wr && !clear_wr && count != '0) |=> (count == $past(count) - 1'b1));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !reload_wr && !clear_wr) |=> $stable(count));

    p_restart_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reload_wr |=> (count == $past(reload_new)));

    p_restart_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_wr && !reload_wr) |=> (count == $past(reload_val)));

    // R11: an access on an expiry edge suppresses the expiry
    p_restart_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_wr || clear_wr) |-> !expire);

endmodule

// File: rtl/wdog_irq_fsm.sv
module wdog_irq_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clear_wr,
    input  logic rst_en,
    input  logic run_en,
    output logic raw_irq,
    output logic irq_out,
    output logic rst_out
);

    irq_state_t state;
    irq_state_t state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            IRQ_IDLE: begin
                if (expire && !clear_wr) state_nxt = IRQ_PENDING;
            end
            IRQ_PENDING: begin
                if (clear_wr)                state_nxt = IRQ_IDLE;
                else if (expire && rst_en)   state_nxt = IRQ_RESET;
            end
            IRQ_RESET: begin
                state_nxt = IRQ_RESET;
            end
            default: state_nxt = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= IRQ_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        raw_irq = (state != IRQ_IDLE);
        rst_out = (state == IRQ_RESET);
        irq_out = raw_irq && run_en;
    end

    p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_irq && !clear_wr) |=> raw_irq);

    p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_wr && !rst_out) |=> !raw_irq);

    p_rst_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |=> rst_out);

    p_rst_needs_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out) |-> $past(raw_irq));

    p_irq_on_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !clear_wr) |=> raw_irq);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              wdog_irq,
    output logic              wdog_rst
);

    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] reload_val;
    logic [DATA_W-1:0] reload_new;
    logic              run_en;
    logic              rst_en;
    logic              reload_wr;
    logic              clear_wr;
    logic              expire;
    logic              raw_irq;

    wdog_regfile #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .pwdata     (pwdata),
        .count      (count),
        .raw_irq    (raw_irq),
        .prdata     (prdata),
        .pready     (pready),
        .reload_val (reload_val),
        .reload_new (reload_new),
        .run_en     (run_en),
        .rst_en     (rst_en),
        .reload_wr  (reload_wr),
        .clear_wr   (clear_wr)
    );

    wdog_counter #(
        .DATA_W (DATA_W)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .reload_wr  (reload_wr),
        .reload_new (reload_new),
        .clear_wr   (clear_wr),
        .reload_val (reload_val),
        .count      (count),
        .expire     (expire)
    );

    wdog_irq_fsm u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire),
        .clear_wr (clear_wr),
        .rst_en   (rst_en),
        .run_en   (run_en),
        .raw_irq  (raw_irq),
        .irq_out  (wdog_irq),
        .rst_out  (wdog_rst)
    );

    // R8: masked output never high while disabled
    p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> !wdog_irq);

endmodule

// File: tb/test_wdog_timer.sv
module test_wdog_timer;

    localparam int DW = 32;
    localparam int AW = 8;

    localparam logic [AW-1:0] A_RELOAD = 8'h00;
    localparam logic [AW-1:0] A_COUNT  = 8'h04;
    localparam logic [AW-1:0] A_CTRL   = 8'h08;
    localparam logic [AW-1:0] A_CLEAR  = 8'h0C;
    localparam logic [AW-1:0] A_RAW    = 8'h10;
    localparam logic [AW-1:0] A_MASKED = 8'h14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0;
    logic          penable = 1'b0;
    logic          pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [DW-1:0] pwdata = '0;
    logic [DW-1:0] prdata;
    logic          pready;
    logic          wdog_irq;
    logic          wdog_rst;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #4 clk = ~clk;

    wdog_timer #(.DATA_W(DW), .ADDR_W(AW)) i_wdog_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .prdata   (prdata),
        .pready   (pready),
        .wdog_irq (wdog_irq),
        .wdog_rst (wdog_rst)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
    endtask

    // monitor: pops the expected item for each read access phase
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (psel && penable && !pwrite) begin
                if (exp_q.size() == 0) begin
                    check("R2 unexpected read", 32'h1, 32'h0);
                end else begin
                    check(tag_q.pop_front(), prdata, exp_q.pop_front());
                    check("R2 pready", {31'b0, pready}, 32'h1);
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 irq after reset", {31'b0, wdog_irq}, 32'h0);
        check("R1 rst after reset", {31'b0, wdog_rst}, 32'h0);
        rd(A_RELOAD, 32'hFFFF_FFFF, "R1 reload reset value");
        rd(A_COUNT,  32'hFFFF_FFFF, "R1 count reset value");
        rd(A_CTRL,   32'h0,         "R1 control reset value");
        rd(A_RAW,    32'h0,         "R1 raw status reset value");
        // R2 unmapped offset
        rd(8'h18, 32'h0, "R2 unmapped read");

        // R3 decrement then hold
        wr(A_CTRL, 32'h1);
        wr(A_RELOAD, 32'd100);
        wr(A_CTRL, 32'h0);
        rd(A_COUNT, 32'd98, "R3 two decrements before halt");
        idle(10);
        rd(A_COUNT, 32'd98, "R3 count held while disabled");

        // R4 zero write stored, no restart; nonzero restarts even when halted
        wr(A_RELOAD, 32'd0);
        rd(A_COUNT, 32'd98, "R4 zero reload leaves count");
        rd(A_RELOAD, 32'd0, "R4 zero reload stored");
        wr(A_RELOAD, 32'd100);
        rd(A_COUNT, 32'd100, "R4 restart while halted");
        wr(A_CTRL, 32'h1);
        wr(A_RELOAD, 32'd500);
        rd(A_COUNT, 32'd499, "R4 restart while running");

        // R5 / R10 / R9 expiry timing and reset path
        wr(A_CTRL, 32'h3);
        rd(A_CTRL, 32'h3, "R2 control readback");
        wr(A_RELOAD, 32'd5);
        check("R5 irq low at load edge", {31'b0, wdog_irq}, 32'h0);
        for (int i = 1; i <= 5; i++) begin
            idle(1);
            check("R5 irq low before expiry", {31'b0, wdog_irq}, 32'h0);
        end
        idle(1);
        check("R5 irq at edge B+N+1", {31'b0, wdog_irq}, 32'h1);
        check("R10 no reset on first expiry", {31'b0, wdog_rst}, 32'h0);
        for (int i = 1; i <= 5; i++) begin
            idle(1);
            check("R9 reset low before second expiry", {31'b0, wdog_rst}, 32'h0);
        end
        idle(1);
        check("R9 reset on second expiry", {31'b0, wdog_rst}, 32'h1);
        wr(A_CLEAR, 32'h1);
        idle(3);
        check("R9 reset ignores clear", {31'b0, wdog_rst}, 32'h1);
        do_reset();
        check("R1 reset output released", {31'b0, wdog_rst}, 32'h0);

        // R6 / R8 / R7 sticky, masking, clear
        wr(A_CTRL, 32'h1);
        wr(A_RELOAD, 32'd3);
        idle(6);
        check("R5 irq after short reload", {31'b0, wdog_irq}, 32'h1);
        wr(A_CLEAR, 32'h0);
        check("R6 clear with bit0 low ignored", {31'b0, wdog_irq}, 32'h1);
        rd(A_RAW, 32'h1, "R8 raw status set");
        rd(A_MASKED, 32'h1, "R8 masked status set");
        wr(A_CTRL, 32'h0);
        check("R8 irq masked by enable", {31'b0, wdog_irq}, 32'h0);
        rd(A_RAW, 32'h1, "R8 raw stays when masked");
        rd(A_MASKED, 32'h0, "R8 masked status clear");
        wr(A_CTRL, 32'h1);
        check("R6 irq returns after re-enable", {31'b0, wdog_irq}, 32'h1);
        wr(A_RELOAD, 32'd1000);
        check("R6 reload write keeps irq", {31'b0, wdog_irq}, 32'h1);
        wr(A_CLEAR, 32'h1);
        check("R7 clear drops irq", {31'b0, wdog_irq}, 32'h0);
        rd(A_COUNT, 32'd999, "R7 clear restarts count");

        // R11 reload on the expiry edge
        wr(A_RELOAD, 32'd3);
        idle(2);
        wr(A_RELOAD, 32'd7);
        check("R11 no irq on colliding expiry", {31'b0, wdog_irq}, 32'h0);
        rd(A_COUNT, 32'd6, "R11 count from new reload");
        for (int i = 1; i <= 5; i++) begin
            idle(1);
            check("R11 irq low during new count", {31'b0, wdog_irq}, 32'h0);
        end
        idle(1);
        check("R5 irq after new count", {31'b0, wdog_irq}, 32'h1);

        idle(2);
        check("R2 all reads consumed", exp_q.size(), 32'h0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule